// File: doc/BRIEF.md
# Multi-Mode 16-bit Timer/Counter

This block is a 16-bit counter that software sets up through a small byte-wide register port. It can run in one of three modes. In the first it is an auto-reload timer, and it can optionally count up or down. In the second it is a free-running timer that records its count when an edge arrives on a trigger pin. In the third it divides the count rate down to a periodic tick for a serial clock. A separate select bit sets what the counter counts. In timer function it counts machine-cycle ticks, which arrive as a single-clock enable. In counter function it counts falling edges on an external pin, and that pin is sampled once per machine cycle.

Two status flags drive the interrupt request: one for overflow and one for trigger events. Hardware only sets these flags. Software clears them by writing the control register. The serial tick output is a one-clock pulse, and the serial logic that consumes it lies outside this block.

Top module: `mt16_timer`

## Requirements
- R1: The register map is: address 0 is control, 1 is count low byte, 2 is count high byte, 3 is hold low byte, 4 is hold high byte. Control bits are: bit0 capture select, bit1 counter function, bit2 run, bit3 trigger enable, bit4 serial-clock mode, bit5 up/down enable, bit6 trigger flag, bit7 overflow flag. After reset, every register, flag and output is zero.
- R2: When run is 0 the block is off. Ticks and pin activity leave the count unchanged.
- R3: In timer function the count advances by exactly one per tick, and it does not change between ticks.
- R4: In auto-reload mode (run=1, serial-clock=0, capture=0, up/down=0), a step from 0xFFFF loads the hold value and sets the overflow flag. The interrupt output is high whenever either flag is set.
- R5: In counter function, a step occurs only when one tick samples the count pin high and the next tick samples it low. The count changes on the tick after the tick that detected the edge. A pin held low adds nothing.
- R6: In capture mode with trigger enable set, a tick that detects a falling edge on the trigger pin does two things: it copies the current count into the hold register and sets the trigger flag. Counting continues. A step from 0xFFFF wraps to 0x0000 and sets the overflow flag.
- R7: When trigger enable is 0, a falling edge on the trigger pin leaves the hold register, the count and the trigger flag unchanged.
- R8: Hardware never clears either flag. A control write loads the flags from the written byte, and a flag being set by hardware in the same cycle stays set.
- R9: In serial-clock mode a step from 0xFFFF loads the hold value and pulses the serial tick for one clock. The overflow flag is not set, and the capture-select bit is ignored.
- R10: In auto-reload mode with trigger enable set and up/down enable clear, a trigger falling edge loads the hold value into the count and sets the trigger flag.
- R11: With up/down enable set in auto-reload mode, a trigger pin sampled high counts up and one sampled low counts down. Counting down from a count equal to the hold value gives 0xFFFF and sets the overflow flag. Counting up from 0xFFFF loads the hold value and sets the overflow flag.
- R12: A write to a count or hold byte takes effect on the next clock. A count write overrides any step in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle enable, one clock wide |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Read data for reg_addr (combinational) |
| cnt_pin | input | 1 | External count input |
| trig_pin | input | 1 | Trigger and direction input |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | Trigger flag |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | Serial clock tick pulse |

## Verification
Most results are due on the clock edge that carries the tick, and the bench samples them at the falling clock edge that follows. This applies to count steps, reloads, captures, flag sets and the serial tick. A pin edge in counter function follows different timing. It is detected on one tick and appears in the count only on the next tick, so the bench checks the count after both ticks and confirms that it is unchanged in between. Each direction change for up/down counting and each settling of a pin is preceded by a tick with run clear, so that the input samplers hold known levels before the checked sequence starts.

// File: rtl/mt16_pkg.sv
package mt16_pkg;

    localparam int BYTE_W = 8;

    // Control byte, MSB first
    typedef struct packed {
        logic ovf;
        logic ext;
        logic dir_en;
        logic baud;
        logic trig_en;
        logic run;
        logic ext_cnt;
        logic cap;
    } ctrl_t;

    typedef enum logic [1:0] {
        M_OFF,
        M_RELOAD,
        M_CAPTURE,
        M_BAUD
    } mode_e;

    function automatic mode_e decode_mode(ctrl_t c);
        if (!c.run)       return M_OFF;
        else if (c.baud)  return M_BAUD;
        else if (c.cap)   return M_CAPTURE;
        else              return M_RELOAD;
    endfunction

endpackage

// File: rtl/mt16_pin_edge.sv
module mt16_pin_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic pin,
    output logic level_q,
    output logic fall_now,
    output logic fall_q
);
    // high sample followed by low sample
    assign fall_now = tick & level_q & ~pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            fall_q  <= 1'b0;
        end else if (tick) begin
            level_q <= pin;
            fall_q  <= level_q & ~pin;
        end
    end
endmodule

// File: rtl/mt16_step.sv
module mt16_step
    import mt16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  mode_e             mode,
    input  logic              dir_en,
    input  logic              up,
    input  logic              step,
    input  logic              trig_hit,
    input  logic              trig_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  hold,
    output logic [CNT_W-1:0]  cnt_nx,
    output logic [CNT_W-1:0]  hold_nx,
    output logic              set_ovf,
    output logic              set_ext,
    output logic              baud_pulse
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic at_top;
    assign at_top = (cnt == TOP);

    always_comb begin
        cnt_nx     = cnt;
        hold_nx    = hold;
        set_ovf    = 1'b0;
        set_ext    = 1'b0;
        baud_pulse = 1'b0;
        case (mode)
            M_CAPTURE: begin
                if (step) begin
                    cnt_nx  = cnt + 1'b1;
                    set_ovf = at_top;
                end
                if (trig_hit && trig_en) begin
                    hold_nx = cnt;
                    set_ext = 1'b1;
                end
            end
            M_RELOAD: begin
                if (step) begin
                    if (dir_en && !up) begin
                        if (cnt == hold) begin
                            cnt_nx  = TOP;
                            set_ovf = 1'b1;
                        end else begin
                            cnt_nx = cnt - 1'b1;
                        end
                    end else if (at_top) begin
                        cnt_nx  = hold;
                        set_ovf = 1'b1;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                if (!dir_en && trig_hit && trig_en) begin
                    cnt_nx  = hold;
                    set_ext = 1'b1;
                end
            end
            M_BAUD: begin
                if (step) begin
                    if (at_top) begin
                        cnt_nx     = hold;
                        baud_pulse = 1'b1;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mt16_timer.sv
module mt16_timer
    import mt16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              irq,
    output logic              baud_tick
);
    localparam int NB        = CNT_W / BYTE_W;
    localparam int CNT_BASE  = 1;
    localparam int HOLD_BASE = CNT_BASE + NB;

    ctrl_t             ctrl_q, ctrl_w;
    logic [CNT_W-1:0]  cnt_q, cnt_w, cnt_nx;
    logic [CNT_W-1:0]  hold_q, hold_w, hold_nx;
    logic              baud_q;
    mode_e             mode;

    logic cnt_lvl, cnt_fall_now, cnt_fall_q;
    logic trg_lvl, trg_fall_now, trg_fall_q;
    logic step, set_ovf, set_ext, baud_pulse;

    assign mode = decode_mode(ctrl_q);

    mt16_pin_edge u_cnt_edge (
        .clk(clk), .rst(rst), .tick(tick), .pin(cnt_pin),
        .level_q(cnt_lvl), .fall_now(cnt_fall_now), .fall_q(cnt_fall_q)
    );

    mt16_pin_edge u_trg_edge (
        .clk(clk), .rst(rst), .tick(tick), .pin(trig_pin),
        .level_q(trg_lvl), .fall_now(trg_fall_now), .fall_q(trg_fall_q)
    );

    assign step = tick & ctrl_q.run & (ctrl_q.ext_cnt ? cnt_fall_q : 1'b1);

    mt16_step #(.CNT_W(CNT_W)) u_step (
        .mode(mode), .dir_en(ctrl_q.dir_en), .up(trg_lvl), .step(step),
        .trig_hit(trg_fall_now), .trig_en(ctrl_q.trig_en),
        .cnt(cnt_q), .hold(hold_q), .cnt_nx(cnt_nx), .hold_nx(hold_nx),
        .set_ovf(set_ovf), .set_ext(set_ext), .baud_pulse(baud_pulse)
    );

    always_comb begin
        ctrl_w = ctrl_q;
        cnt_w  = cnt_nx;
        hold_w = hold_nx;
        if (wr_en && reg_addr == '0)
            ctrl_w = ctrl_t'(wr_data);
        for (int i = 0; i < NB; i++) begin
            if (wr_en && reg_addr == ADDR_W'(CNT_BASE + i)) begin
                cnt_w = cnt_q;
                cnt_w[BYTE_W*i +: BYTE_W] = wr_data;
            end
            if (wr_en && reg_addr == ADDR_W'(HOLD_BASE + i))
                hold_w[BYTE_W*i +: BYTE_W] = wr_data;
        end
        ctrl_w.ovf = ctrl_w.ovf | set_ovf;
        ctrl_w.ext = ctrl_w.ext | set_ext;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
            baud_q <= 1'b0;
        end else begin
            ctrl_q <= ctrl_w;
            cnt_q  <= cnt_w;
            hold_q <= hold_w;
            baud_q <= baud_pulse;
        end
    end

    always_comb begin
        rd_data = '0;
        if (reg_addr == '0)
            rd_data = ctrl_q;
        for (int i = 0; i < NB; i++) begin
            if (reg_addr == ADDR_W'(CNT_BASE + i))
                rd_data = cnt_q[BYTE_W*i +: BYTE_W];
            if (reg_addr == ADDR_W'(HOLD_BASE + i))
                rd_data = hold_q[BYTE_W*i +: BYTE_W];
        end
    end

    assign ovf_flag  = ctrl_q.ovf;
    assign ext_flag  = ctrl_q.ext;
    assign irq       = ctrl_q.ovf | ctrl_q.ext;
    assign baud_tick = baud_q;

endmodule

// File: rtl/mt16_timer_chk.sv
module mt16_timer_chk
    import mt16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input mode_e             mode,
    input logic              ovf_flag,
    input logic              ext_flag,
    input logic              baud_tick
);
    // R2
    off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !wr_en) |=> $stable(cnt));

    // R3
    tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr_en) |=> $stable(cnt));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(wr_en && reg_addr == '0));

    // R8
    ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_flag) |-> $past(wr_en && reg_addr == '0));

    // R9
    baud_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == M_BAUD && !(wr_en && reg_addr == '0)) |=> !$rose(ovf_flag));

    // R9
    baud_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        baud_tick |-> $past(tick));
endmodule

bind mt16_timer mt16_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .reg_addr(reg_addr),
    .cnt(cnt_q), .run(ctrl_q.run), .mode(mode),
    .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick)
);

// File: tb/test_mt16_timer.sv
module test_mt16_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       ovf_flag, ext_flag, irq, baud_tick;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] C_CAP = 8'h01, C_EXT = 8'h02, C_RUN = 8'h04,
                           C_TEN = 8'h08, C_BAUD = 8'h10, C_DIR = 8'h20;

    always #10 clk = ~clk;

    mt16_timer i_mt16_timer (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq), .baud_tick(baud_tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] d);
        wr(a, d[7:0]);
        wr(a + 3'd1, d[15:8]);
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; #1 d[7:0] = rd_data;
        reg_addr = a + 3'd1; #1 d[15:8] = rd_data;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    // idle the block and settle both pin samplers
    task automatic settle(input logic cp, input logic tp);
        wr(3'd0, 8'h00);
        cnt_pin = cp; trig_pin = tp;
        do_tick(); do_tick();
    endtask

    task automatic t_reset();
        logic [15:0] v;
        @(negedge clk); reg_addr = 3'd0; #1;
        chk("R1 ctrl", rd_data, 8'h00);
        rd16(3'd1, v); chk("R1 count", v, 16'h0);
        rd16(3'd3, v); chk("R1 hold", v, 16'h0);
        chk("R1 irq", {ovf_flag, ext_flag, irq, baud_tick}, 4'b0);
    endtask

    task automatic t_off();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'h0042);
        do_tick(); do_tick();
        trig_pin = 1'b0; do_tick();
        rd16(3'd1, v); chk("R2 off count", v, 16'h0042);
        chk("R2 off flags", irq, 1'b0);
    endtask

    task automatic t_reload_up();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd3, 16'h1234);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, C_RUN);
        rd16(3'd1, v); chk("R3 no tick no step", v, 16'hFFFE);
        do_tick();
        rd16(3'd1, v); chk("R3 one step", v, 16'hFFFF);
        chk("R4 no ovf yet", ovf_flag, 1'b0);
        do_tick();
        rd16(3'd1, v); chk("R4 reload", v, 16'h1234);
        chk("R4 ovf", ovf_flag, 1'b1);
        chk("R4 irq", irq, 1'b1);
        do_tick(); do_tick();
        chk("R8 ovf sticky", ovf_flag, 1'b1);
        rd16(3'd1, v); chk("R3 counting on", v, 16'h1236);
        wr(3'd0, C_RUN);
        chk("R8 sw clear", {ovf_flag, irq}, 2'b00);
    endtask

    task automatic t_counter();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'h0000);
        wr(3'd0, C_RUN | C_EXT);
        do_tick();
        rd16(3'd1, v); chk("R5 high no count", v, 16'h0000);
        cnt_pin = 1'b0; do_tick();
        rd16(3'd1, v); chk("R5 detect tick", v, 16'h0000);
        do_tick();
        rd16(3'd1, v); chk("R5 count next tick", v, 16'h0001);
        do_tick(); do_tick();
        rd16(3'd1, v); chk("R5 steady low", v, 16'h0001);
        cnt_pin = 1'b1; do_tick();
        cnt_pin = 1'b0; do_tick(); do_tick();
        rd16(3'd1, v); chk("R5 second edge", v, 16'h0002);
    endtask

    task automatic t_capture();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'h0100);
        wr16(3'd3, 16'h5555);
        wr(3'd0, C_RUN | C_CAP | C_TEN);
        do_tick();
        trig_pin = 1'b0; do_tick();
        rd16(3'd3, v); chk("R6 captured", v, 16'h0101);
        rd16(3'd1, v); chk("R6 count continues", v, 16'h0102);
        chk("R6 ext flag", {ext_flag, irq}, 2'b11);
        do_tick();
        rd16(3'd3, v); chk("R6 no recapture", v, 16'h0101);
        wr16(3'd1, 16'hFFFF);
        do_tick();
        rd16(3'd1, v); chk("R6 wrap", v, 16'h0000);
        chk("R6 ovf", ovf_flag, 1'b1);
    endtask

    task automatic t_trig_off();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'h0200);
        wr16(3'd3, 16'h5555);
        wr(3'd0, C_RUN | C_CAP);
        trig_pin = 1'b0; do_tick();
        rd16(3'd3, v); chk("R7 hold kept", v, 16'h5555);
        rd16(3'd1, v); chk("R7 count", v, 16'h0201);
        chk("R7 ext", ext_flag, 1'b0);
    endtask

    task automatic t_trig_reload();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'h0005);
        wr16(3'd3, 16'h0AA0);
        wr(3'd0, C_RUN | C_TEN);
        trig_pin = 1'b0; do_tick();
        rd16(3'd1, v); chk("R10 reload", v, 16'h0AA0);
        chk("R10 ext", ext_flag, 1'b1);
        chk("R10 no ovf", ovf_flag, 1'b0);
    endtask

    task automatic t_updown();
        logic [15:0] v;
        settle(1'b1, 1'b0);
        wr16(3'd3, 16'h0010);
        wr16(3'd1, 16'h0011);
        wr(3'd0, C_RUN | C_DIR | C_TEN);
        do_tick();
        rd16(3'd1, v); chk("R11 down", v, 16'h0010);
        chk("R11 no ovf yet", ovf_flag, 1'b0);
        do_tick();
        rd16(3'd1, v); chk("R11 underflow", v, 16'hFFFF);
        chk("R11 ovf", ovf_flag, 1'b1);
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'hFFFF);
        wr(3'd0, C_RUN | C_DIR | C_TEN);
        trig_pin = 1'b0;
        do_tick();
        rd16(3'd1, v); chk("R11 up reload", v, 16'h0010);
        chk("R11 up ovf, trigger no ext", {ovf_flag, ext_flag}, 2'b10);
    endtask

    task automatic t_baud();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd3, 16'hFFFD);
        wr16(3'd1, 16'hFFFE);
        wr(3'd0, C_RUN | C_BAUD | C_CAP);
        do_tick();
        chk("R9 no tick yet", baud_tick, 1'b0);
        do_tick();
        chk("R9 baud tick", baud_tick, 1'b1);
        rd16(3'd1, v); chk("R9 reload", v, 16'hFFFD);
        chk("R9 no ovf", ovf_flag, 1'b0);
        @(negedge clk);
        chk("R9 one clock", baud_tick, 1'b0);
    endtask

    task automatic t_write_wins();
        logic [15:0] v;
        settle(1'b1, 1'b1);
        wr16(3'd1, 16'h0300);
        wr(3'd0, C_RUN);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = 3'd1; wr_data = 8'h77; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd16(3'd1, v); chk("R12 write overrides step", v, 16'h0377);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_off();
        t_reload_up();
        t_counter();
        t_capture();
        t_trig_off();
        t_trig_reload();
        t_updown();
        t_baud();
        t_write_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule